// File: doc/BRIEF.md
# Serial Flash Status Register Engine

This block is the slave-side status logic of a serial memory. It watches a serial clock, an active-low chip select and a serial data input, all oversampled in the system clock domain. From that stream it decodes three instructions: setting the write-enable latch, reading the status byte, and writing the status byte. During a status read it shifts the status byte out MSB first. It also holds the protection state: two block-protect bits, a write-disable bit and the gating that the write-protect pin applies.

A status write takes effect only if three things hold. The frame carries exactly one opcode byte and one data byte. The enable latch was set by an earlier frame. The chip is neither busy nor hardware-protected. A status write that takes effect starts a self-timed busy period. Its length is `WRITE_CYCLES` system clocks. During that period the busy bit can be polled through status reads, and every other instruction is ignored.

Top module: `sflash_status_engine`

## Requirements
- R1: After reset the status byte reads 0x00 and `sdo_oe_o` is low.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets the enable latch. The latch is status bit 1.
- R3: Opcode 0x05 returns the status byte MSB first, one bit per serial clock, changing on the falling edge. The byte is repeated for as long as chip select stays low. The layout is bit7 write-disable, bits 6:4 zero, bits 3:2 block-protect, bit1 enable latch, bit0 busy. `sdo_oe_o` is high while the byte is being driven.
- R4: A status write (opcode 0x01 followed by one data byte) loads bit 7 and bits 3:2 from the data byte. Bits 6:4 still read 0 and bits 1:0 are not taken from the data.
- R5: A status write is ignored when the enable latch is clear.
- R6: A status write frame ended after any count other than exactly 16 bits is discarded, and the enable latch is kept.
- R7: An accepted status write sets the busy bit for `WRITE_CYCLES` clocks and clears the enable latch when the busy period starts.
- R8: While busy, the enable opcode has no effect, but status reads still work.
- R9: When the write-disable bit is 1 and `wp_ni` is low, status writes are ignored. With `wp_ni` high they are accepted.
- R10: `sdo_oe_o` is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in, sampled on rising sck |
| wp_ni | input | 1 | Write protect, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low means high impedance) |

## Verification
The busy countdown and a status read can overlap. The busy bit may drop while a polling read is in progress inside a single chip-select frame. The bench provokes this by releasing chip select on an accepted write and then reading status bytes back to back in one frame. It judges the result by three conditions: the first byte shows busy with the latch already clear, busy falls exactly once and never returns, and the number of bytes read before it falls fits the configured duration. A second overlap sends the enable opcode inside the busy window and then confirms, after the window, that the latch stayed clear.

// File: rtl/sfse_pkg.sv
package sfse_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef struct packed {
    logic       srwd;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
  } sts_t;

  function automatic logic [7:0] sts_byte(sts_t s);
    return {s.srwd, 3'b000, s.bp, s.wel, s.wip};
  endfunction
endpackage

// File: rtl/sfse_sync.sv
module sfse_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sfse_shift.sv
module sfse_shift #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_s_i,
  input  logic             csn_s_i,
  input  logic             sdi_s_i,
  output logic             sck_rise_o,
  output logic             sck_fall_o,
  output logic             cs_rise_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [2:0]       bit_pos_o,
  output logic [7:0]       opcode_o,
  output logic [7:0]       shreg_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(7);

  logic sck_q, csn_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      csn_q <= csn_s_i;
    end

  assign sck_rise_o = sck_s_i & ~sck_q & ~csn_s_i;
  assign sck_fall_o = ~sck_s_i & sck_q & ~csn_s_i;
  assign cs_rise_o  = csn_s_i & ~csn_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bit_cnt_o <= '0;
      bit_pos_o <= '0;
      opcode_o  <= '0;
      shreg_o   <= '0;
    end else if (csn_s_i) begin
      bit_cnt_o <= '0;
      bit_pos_o <= '0;
    end else if (sck_rise_o) begin
      shreg_o   <= {shreg_o[6:0], sdi_s_i};
      bit_pos_o <= bit_pos_o + 3'd1;
      if (bit_cnt_o != CNT_MAX) bit_cnt_o <= bit_cnt_o + 1'b1;
      if (bit_cnt_o == OP_LAST) opcode_o <= {shreg_o[6:0], sdi_s_i};
    end

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> (bit_cnt_o == '0)); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csn_s_i && !sck_rise_o) |=> $stable(bit_cnt_o)); // R6
endmodule

// File: rtl/sfse_status.sv
module sfse_status
  import sfse_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wren_i,
  input  logic       wrsr_i,
  input  logic [2:0] wdata_i,   // {srwd, bp1, bp0}
  input  logic       wp_n_i,
  output sts_t       sts_o
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic hpm, accept;

  assign hpm    = sts_o.srwd & ~wp_n_i;
  assign accept = wrsr_i & sts_o.wel & ~sts_o.wip & ~hpm;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sts_o <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      sts_o.srwd <= wdata_i[2];
      sts_o.bp   <= wdata_i[1:0];
      sts_o.wel  <= 1'b0;
      sts_o.wip  <= 1'b1;
      cnt_q      <= CNT_LOAD;
    end else begin
      if (sts_o.wip) begin
        if (cnt_q == '0) sts_o.wip <= 1'b0;
        else             cnt_q     <= cnt_q - 1'b1;
      end
      if (wren_i && !sts_o.wip) sts_o.wel <= 1'b1;
    end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD); // R7
  AST_WEL_CLR_ON_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o.wip) |-> !sts_o.wel); // R7
  AST_WEL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o.wip) |-> $past(sts_o.wel)); // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o.wip && $past(sts_o.wip)) |-> ($stable(sts_o.bp) && $stable(sts_o.srwd))); // R8
  AST_BUSY_NO_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o.wip |=> !sts_o.wel); // R8
  AST_HPM_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpm |=> ($stable(sts_o.bp) && $stable(sts_o.srwd))); // R9
endmodule

// File: rtl/sflash_status_engine.sv
module sflash_status_engine
  import sfse_pkg::*;
#(
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic sdi_i,
  input  logic wp_ni,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] LEN_CMD  = CNT_W'(8);
  localparam logic [CNT_W-1:0] LEN_DATA = CNT_W'(16);

  logic [3:0] raw_in, syn_in;
  logic sck_s, csn_s, sdi_s, wp_s;

  assign raw_in = {wp_ni, sdi_i, csn_i, sck_i};

  sfse_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );
  assign {wp_s, sdi_s, csn_s, sck_s} = syn_in;

  logic             sck_rise, sck_fall, cs_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic [2:0]       bit_pos;
  logic [7:0]       opcode, shreg;

  sfse_shift #(.CNT_W(CNT_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .csn_s_i   (csn_s),
    .sdi_s_i   (sdi_s),
    .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall),
    .cs_rise_o (cs_rise),
    .bit_cnt_o (bit_cnt),
    .bit_pos_o (bit_pos),
    .opcode_o  (opcode),
    .shreg_o   (shreg)
  );

  logic wren_cmd, wrsr_cmd;
  // commands commit only on chip-select release at an exact byte boundary
  assign wren_cmd = cs_rise && (bit_cnt == LEN_CMD)  && (opcode == OP_WREN);
  assign wrsr_cmd = cs_rise && (bit_cnt == LEN_DATA) && (opcode == OP_WRSR);

  sts_t sts;

  sfse_status #(.WRITE_CYCLES(WRITE_CYCLES)) i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wren_i (wren_cmd),
    .wrsr_i (wrsr_cmd),
    .wdata_i({shreg[7], shreg[3:2]}),
    .wp_n_i (wp_s),
    .sts_o  (sts)
  );

  logic       rd_act;
  logic [7:0] tx_q;

  assign rd_act = !csn_s && (opcode == OP_RDSR) && (bit_cnt >= LEN_CMD);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      tx_q     <= '0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (csn_s) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (sck_fall && rd_act) begin
      sdo_oe_o <= 1'b1;
      if (bit_pos == 3'd0) begin
        // fresh snapshot at every byte boundary so polling sees busy drop
        sdo_o <= sts_byte(sts)[7];
        tx_q  <= {sts_byte(sts)[6:0], 1'b0};
      end else begin
        sdo_o <= tx_q[7];
        tx_q  <= {tx_q[6:0], 1'b0};
      end
    end

  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> !sdo_oe_o); // R10
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts.wip) |-> $past(wrsr_cmd)); // R7
  AST_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall && rd_act && bit_pos >= 3'd1 && bit_pos <= 3'd3) |=> !sdo_o); // R4
endmodule

// File: tb/test_sflash_status_engine.sv
module test_sflash_status_engine;
  localparam int WC   = 200;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0, wp_n = 1'b1;
  logic sdo, sdo_oe;

  always #5 clk = ~clk;

  sflash_status_engine #(.WRITE_CYCLES(WC)) i_sflash_status_engine (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
    .wp_ni(wp_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: pops scoreboard entries as the driver produces them
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) chk(got_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic bit_xfer(input logic b, output logic r);
    sdi = b;
    repeat (HALF) @(negedge clk);
    r = sdo;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    logic r;
    for (int i = n - 1; i >= 0; i--) bit_xfer(i < 16 ? v[i] : 1'b0, r);
  endtask

  task automatic cs_low();
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b0, r);
      v[i] = r;
    end
    // the capture of the last bit happens one more sck high later in a real master;
    // here sdo of bit0 was sampled before its rising edge
  endtask

  // driver: queue expected status bytes, one frame
  task automatic rdsr(input logic [7:0] exp, input int nbytes, input string tag);
    logic [7:0] v;
    cs_low();
    send_bits(16'h0005, 8);
    for (int k = 0; k < nbytes; k++) begin
      read_byte(v);
      exp_q.push_back(exp); tag_q.push_back(tag); got_q.push_back(v);
    end
    chk({7'd0, sdo_oe}, 8'd1, "R3 oe during read");
    cs_high();
    chk({7'd0, sdo_oe}, 8'd0, "R10 oe after release");
  endtask

  task automatic wren();
    cs_low(); send_bits(16'h0006, 8); cs_high();
  endtask

  task automatic wrsr(input logic [7:0] d, input int nbits);
    cs_low();
    send_bits({8'h01, d}, 16);
    if (nbits > 16) send_bits(16'h0001, nbits - 16);
    if (nbits < 16) begin
      // not reached: short frames built separately
    end
    cs_high();
  endtask

  task automatic wrsr_short(input logic [7:0] d);
    cs_low();
    send_bits({1'b0, 8'h01, d[7:1]}, 15);
    cs_high();
  endtask

  task automatic poll(input logic [7:0] busy_exp, input logic [7:0] idle_exp, input string tag);
    logic [7:0] v;
    int n = 0;
    bit seen_idle = 0;
    cs_low();
    send_bits(16'h0005, 8);
    read_byte(v);
    n++;
    chk(v, busy_exp, {tag, " first poll busy"});
    for (int k = 0; k < 10 && !seen_idle; k++) begin
      read_byte(v);
      n++;
      if (v[0] == 1'b0) begin
        seen_idle = 1;
        chk(v, idle_exp, {tag, " idle byte"});
      end else chk(v, busy_exp, {tag, " busy byte"});
    end
    read_byte(v);
    chk(v, idle_exp, {tag, " stays idle"});
    cs_high();
    chk({7'd0, seen_idle}, 8'd1, {tag, " busy ended"});
    chk({7'd0, (n >= 2 && n <= 6)}, 8'd1, {tag, " busy length"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({7'd0, sdo_oe}, 8'd0, "R1 oe in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk({7'd0, sdo_oe}, 8'd0, "R10 oe idle");
    rdsr(8'h00, 1, "R1 status after reset");

    wrsr(8'hFF, 16);
    rdsr(8'h00, 1, "R5 write without latch");

    wren();
    rdsr(8'h02, 1, "R2 latch set");

    wrsr_short(8'h8C);
    rdsr(8'h02, 1, "R6 15-bit frame");
    wrsr(8'h8C, 17);
    rdsr(8'h02, 1, "R6 17-bit frame");

    wrsr(8'h7C, 16);
    poll(8'h0D, 8'h0C, "R7");
    rdsr(8'h0C, 2, "R4 data bits 6:4 read zero, R3 repeat");

    wren();
    wrsr(8'h80, 16);
    wren();                      // inside busy window
    repeat (WC + 100) @(negedge clk);
    rdsr(8'h80, 1, "R8 latch not set while busy");

    wp_n = 1'b0;
    wren();
    rdsr(8'h82, 1, "R9 latch set under protect");
    wrsr(8'h0C, 16);
    repeat (WC + 50) @(negedge clk);
    rdsr(8'h82, 1, "R9 protected write ignored");

    wp_n = 1'b1;
    repeat (4) @(negedge clk);
    wrsr(8'h0C, 16);
    repeat (WC + 50) @(negedge clk);
    rdsr(8'h0C, 3, "R9 write accepted, R3 multi-byte");

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule